// File: doc/BRIEF.md
# Stepped-Frequency Chirp Pulse Generator

This block makes a square-wave burst for an ultrasonic transducer. The frequency of the burst climbs in discrete steps. A down-counter that runs on the system clock sets the length of each output cycle. At a 10 MHz clock, one count is 100 ns. The burst opens at a long period, about 38 kHz at 262 counts. Each time a fixed dwell interval expires, the period is shortened by a fixed step. The sweep stops once the end period, about 42 kHz at 238 counts, has been held for its own dwell. The high time of every cycle is half the period, truncated to an integer, so the duty is nominally 50%.

The host raises a start line to launch a burst. A busy flag covers the whole burst. A falling edge on the kill line ends the burst early. Every stop, whether natural or forced, waits for the current output cycle to finish, so a cycle is never cut short. The start period, end period, step and dwell length are parameters. A step of 2 counts with a 4000-clock dwell keeps every period even, which gives an exact 50% duty.

Top module: `chirp_burst`

## Requirements
- R1: An active-low reset forces the output low and busy low, and reloads the start period, so the next burst begins at the start period.
- R2: A rising edge of `start_i` while idle begins a burst. Busy is high from the clock after that edge, and the first output cycle uses the start period with its high phase first.
- R3: Every output cycle is high for floor(P/2) clocks and then low for the remaining clocks, where P is the period of that cycle.
- R4: The periods of a burst follow the sequence START, START-STEP, START-2*STEP, and so on. Successive cycles either keep the same period or drop by exactly STEP. No period falls below the end value. In a burst that runs to completion, the last period is the lowest member of the sequence that is at least the end value.
- R5: The dwell timer counts DWELL system clocks per setting, starting from the launch. The start period therefore appears for exactly ceil(DWELL/START) complete cycles.
- R6: A new period takes effect only at a cycle boundary, when the counter reloads. No cycle is shortened or stretched; this includes the final cycle of a burst.
- R7: After the last setting's dwell expires, the current cycle completes and then the burst ends. Busy falls and the output stays low. With N settings, busy is high for more than N*DWELL clocks and for at most N*DWELL+START clocks.
- R8: A start edge while busy is ignored, so the burst has the same length as an undisturbed one. A start held high after a burst does not launch another.
- R9: A falling edge of `kill_i` while busy ends the burst at the end of the current cycle, within START+1 clocks. Kill activity while idle has no effect.
- R10: The output is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the counting time base |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A rising edge launches a burst |
| kill_i | input | 1 | A falling edge ends a running burst at the next cycle boundary |
| tone_o | output | 1 | Square-wave drive output |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
An undisturbed burst with odd periods is the reference. It shows that integer halving truncates the high phase, that the period steps down one setting at a time, and that the burst ends exactly on a cycle boundary. A second start pulse in the middle of a burst must give a burst of identical length, which separates ignoring a restart from honoring it. A start held high after the end must not launch a second burst, which separates edge triggering from level triggering. A kill falling edge in mid-sweep must give a shortened burst whose final cycle is still whole, while kill toggles during idle must change nothing. A reset in the middle of a burst, followed by a fresh burst, must reproduce the reference length and the start period, which shows that the start period is reloaded.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/chirp_edge.sv
module chirp_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse_o = s_q.prev & ~sig_i;
        end else begin : g_rise
            assign pulse_o = ~s_q.prev & sig_i;
        end
    endgenerate
endmodule

// File: rtl/chirp_tone.sv
module chirp_tone #(
    parameter int PW      = 9,
    parameter int RST_PER = 262
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          load_i,
    input  logic [PW-1:0] per_i,
    output logic          tone_o,
    output logic          wrap_o,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] per_o
);
    localparam logic [PW-1:0] RST_P  = PW'(RST_PER);
    localparam logic [PW-1:0] RST_LO = PW'(RST_PER - RST_PER / 2);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
        logic [PW-1:0] lo;
    } tone_t;

    tone_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = per_i - PW'(1);
            s_d.per = per_i;
            s_d.lo  = per_i - (per_i >> 1);
        end else if (en_i && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.per <= RST_P;
            s_q.lo  <= RST_LO;
        end else begin
            s_q <= s_d;
        end
    end

    // High while the count is in the upper floor(P/2) slots of the cycle.
    assign tone_o = en_i && (s_q.cnt >= s_q.lo);
    assign wrap_o = (s_q.cnt == '0);
    assign cnt_o  = s_q.cnt;
    assign per_o  = s_q.per;
endmodule

// File: rtl/chirp_dwell.sv
module chirp_dwell #(
    parameter int DWELL = 2000,
    parameter int DW    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic load_i,
    output logic expire_o
);
    localparam logic [DW-1:0] TOP = DW'(DWELL - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } dwell_t;

    dwell_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = TOP;
        end else if (en_i) begin
            if (s_q.cnt == '0) s_d.cnt = TOP;
            else               s_d.cnt = s_q.cnt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expire_o = en_i && !load_i && (s_q.cnt == '0);
endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_pkg::*;
#(
    parameter int PW        = 9,
    parameter int START_PER = 262,
    parameter int END_PER   = 238,
    parameter int STEP      = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          kill_i,
    input  logic          expire_i,
    input  logic          wrap_i,
    output logic          busy_o,
    output logic          load_o,
    output logic          dwell_load_o,
    output logic [PW-1:0] per_next_o
);
    localparam logic [PW-1:0] START_P = PW'(START_PER);
    localparam logic [PW-1:0] STEP_P  = PW'(STEP);
    localparam logic [PW:0]   LIMIT   = (PW+1)'(END_PER + STEP);

    typedef struct packed {
        seq_state_t    state;
        logic [PW-1:0] pend;
    } seq_t;

    seq_t s_d, s_q;
    logic last_set;
    logic stop_req;

    always_comb begin
        s_d          = s_q;
        load_o       = 1'b0;
        dwell_load_o = 1'b0;
        per_next_o   = s_q.pend;
        last_set     = ({1'b0, s_q.pend} < LIMIT);
        stop_req     = kill_i || (expire_i && last_set);
        unique case (s_q.state)
            SEQ_IDLE: begin
                per_next_o = START_P;
                if (go_i) begin
                    s_d.state    = SEQ_RUN;
                    s_d.pend     = START_P;
                    load_o       = 1'b1;
                    dwell_load_o = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (expire_i && !last_set) s_d.pend = s_q.pend - STEP_P;
                if (wrap_i) begin
                    if (stop_req) s_d.state = SEQ_IDLE;
                    else          load_o    = 1'b1;
                end else if (stop_req) begin
                    s_d.state = SEQ_DRAIN;
                end
            end
            SEQ_DRAIN: begin
                if (wrap_i) s_d.state = SEQ_IDLE;
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SEQ_IDLE;
            s_q.pend  <= START_P;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.state != SEQ_IDLE);
endmodule

// File: rtl/chirp_burst.sv
module chirp_burst #(
    parameter int START_PER = 262,
    parameter int END_PER   = 238,
    parameter int STEP      = 1,
    parameter int DWELL     = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic kill_i,
    output logic tone_o,
    output logic busy_o
);
    localparam int PW = $clog2(START_PER + 1);
    localparam int DW = $clog2(DWELL + 1);

    logic          go;
    logic          kill_fall;
    logic          expire;
    logic          wrap;
    logic          load;
    logic          dwell_load;
    logic          busy;
    logic [PW-1:0] per_next;
    logic [PW-1:0] tone_cnt;
    logic [PW-1:0] tone_per;

    chirp_edge #(.FALLING(1'b0)) u_start_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_i   (start_i),
        .pulse_o (go)
    );

    chirp_edge #(.FALLING(1'b1)) u_kill_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_i   (kill_i),
        .pulse_o (kill_fall)
    );

    chirp_seq #(
        .PW        (PW),
        .START_PER (START_PER),
        .END_PER   (END_PER),
        .STEP      (STEP)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .kill_i       (kill_fall),
        .expire_i     (expire),
        .wrap_i       (wrap),
        .busy_o       (busy),
        .load_o       (load),
        .dwell_load_o (dwell_load),
        .per_next_o   (per_next)
    );

    chirp_dwell #(
        .DWELL (DWELL),
        .DW    (DW)
    ) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (busy),
        .load_i   (dwell_load),
        .expire_o (expire)
    );

    chirp_tone #(
        .PW      (PW),
        .RST_PER (START_PER)
    ) u_tone (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .load_i (load),
        .per_i  (per_next),
        .tone_o (tone_o),
        .wrap_o (wrap),
        .cnt_o  (tone_cnt),
        .per_o  (tone_per)
    );

    assign busy_o = busy;
endmodule

// File: rtl/chirp_burst_chk.sv
module chirp_burst_chk #(
    parameter int PW        = 9,
    parameter int START_PER = 262,
    parameter int END_PER   = 238
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          tone_o,
    input logic          busy_o,
    input logic [PW-1:0] cnt,
    input logic [PW-1:0] per
);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tone_o);

    a_r2_launch_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r6_period_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && ($past(cnt) != '0)) |-> $stable(per));

    a_r4_period_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((per <= PW'(START_PER)) && (per >= PW'(END_PER))));

    a_r7_end_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cnt) == '0));

    a_r3_high_phase_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_o) |-> ((cnt + PW'(1)) == per));
endmodule

bind chirp_burst chirp_burst_chk #(
    .PW        (PW),
    .START_PER (START_PER),
    .END_PER   (END_PER)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tone_o  (tone_o),
    .busy_o  (busy_o),
    .cnt     (tone_cnt),
    .per     (tone_per)
);

// File: tb/chirp_burst_test.sv
module chirp_burst_test;
    localparam int CLK_PERIOD = 10;
    localparam int SP = 21;
    localparam int EP = 13;
    localparam int ST = 2;
    localparam int DWL = 60;
    localparam int NSET = (SP - EP) / ST + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic kill_i = 1'b0;
    logic tone_o;
    logic busy_o;

    int checks = 0;
    int errors = 0;
    int per_log [64];
    int hi_log [64];
    int n_cyc, busy_len, last_span, last_hi, end_idx, first_tone, ref_len;

    chirp_burst #(.START_PER(SP), .END_PER(EP), .STEP(ST), .DWELL(DWL)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .kill_i  (kill_i),
        .tone_o  (tone_o),
        .busy_o  (busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit valid_per(input int p);
        return (p <= SP) && (p >= EP) && ((SP - p) % ST == 0);
    endfunction

    // Launch a burst and record each full cycle until busy drops.
    task automatic run_burst(input int kill_fall_at, input int restart_at, input bit hold);
        int idx = 0;
        int rise = -1;
        int hic = 0;
        bit pt = 1'b0;
        n_cyc = 0;
        busy_len = 0;
        first_tone = 0;
        @(negedge clk) start_i = 1'b1;
        forever begin
            @(negedge clk);
            if (!busy_o) break;
            if (idx == 0) first_tone = tone_o;
            busy_len++;
            if (tone_o && !pt) begin
                if (rise >= 0 && n_cyc < 64) begin
                    per_log[n_cyc] = idx - rise;
                    hi_log[n_cyc]  = hic;
                    n_cyc++;
                end
                rise = idx;
                hic = 0;
            end
            if (tone_o) hic++;
            pt = tone_o;
            if (idx == 0 && !hold) start_i = 1'b0;
            if (idx == 5 && kill_fall_at > 0) kill_i = 1'b1;
            if (idx == kill_fall_at) kill_i = 1'b0;
            if (restart_at >= 0 && idx == restart_at) start_i = 1'b1;
            if (restart_at >= 0 && idx == restart_at + 2) start_i = 1'b0;
            idx++;
            if (idx > 4000) break;
        end
        last_span = idx - rise;
        last_hi   = hic;
        end_idx   = idx;
    endtask

    // Shape checks common to every burst.
    task automatic check_shape();
        bit duty_ok = 1'b1;
        bit seq_ok = 1'b1;
        int bad_a = 0;
        int bad_e = 0;
        chk(busy_len > 0 && first_tone == 1, "R2 burst launched high", first_tone, 1);
        chk(n_cyc > 0 && per_log[0] == SP, "R2 first period", per_log[0], SP);
        for (int i = 0; i < n_cyc; i++) begin
            if (hi_log[i] != per_log[i] / 2) begin
                duty_ok = 1'b0; bad_a = hi_log[i]; bad_e = per_log[i] / 2;
            end
            if (!valid_per(per_log[i])) seq_ok = 1'b0;
            if (i > 0 && per_log[i] != per_log[i-1] && per_log[i] != per_log[i-1] - ST)
                seq_ok = 1'b0;
        end
        chk(duty_ok, "R3 high time floor(P/2)", bad_a, bad_e);
        chk(seq_ok, "R4 period sequence", 0, 1);
        chk(valid_per(last_span) && last_hi == last_span / 2,
            "R6 final cycle whole", last_hi, last_span / 2);
        chk(!tone_o && !busy_o, "R10 quiet after burst", tone_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #(CLK_PERIOD * 3);
        #1;
        chk(!tone_o && !busy_o, "R1 reset state", {tone_o, busy_o}, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_full_burst();
        int n_first = 0;
        run_burst(-1, -1, 1'b0);
        check_shape();
        chk(last_span == EP, "R4 last period at end value", last_span, EP);
        for (int i = 0; i < n_cyc; i++) if (per_log[i] == SP) n_first++;
        chk(n_first == (DWL + SP - 1) / SP, "R5 cycles at start period", n_first, (DWL + SP - 1) / SP);
        chk(busy_len > NSET * DWL && busy_len <= NSET * DWL + SP,
            "R7 burst length", busy_len, NSET * DWL);
        ref_len = busy_len;
    endtask

    task automatic t_restart_ignored();
        run_burst(-1, 100, 1'b0);
        check_shape();
        chk(busy_len == ref_len, "R8 restart ignored", busy_len, ref_len);
    endtask

    task automatic t_start_held();
        run_burst(-1, -1, 1'b1);
        chk(busy_len == ref_len, "R8 held start burst", busy_len, ref_len);
        repeat (30) @(negedge clk);
        chk(!busy_o, "R8 held start no retrigger", busy_o, 0);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_kill();
        run_burst(110, -1, 1'b0);
        check_shape();
        chk(end_idx - 110 <= SP + 1, "R9 kill stop latency", end_idx - 110, SP + 1);
        chk(busy_len < NSET * DWL, "R9 kill shortened burst", busy_len, NSET * DWL);
    endtask

    task automatic t_kill_idle();
        @(negedge clk) kill_i = 1'b1;
        repeat (3) @(negedge clk);
        kill_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy_o && !tone_o, "R9 kill idle no effect", busy_o, 0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (150) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!tone_o && !busy_o, "R1 reset mid burst", {tone_o, busy_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        run_burst(-1, -1, 1'b0);
        check_shape();
        chk(busy_len == ref_len, "R1 start period reloaded", busy_len, ref_len);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        t_full_burst();
        t_restart_ignored();
        t_start_held();
        t_kill();
        t_kill_idle();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule